// File: doc/BRIEF.md
# Queued serial transfer sequencer

This block walks a small pointer through a queue of serial transfer entries and drives one serial transfer per entry. Software programs a first and a last queue address, chooses whether the walk stops or wraps when the last address completes, and picks where a wrap resumes. A pulse on `go` starts the walk at the first address. A built-in stand-in shifter moves one data word per entry. The data for the entry comes from outside and is selected by the reported pointer. The received word comes back with a valid strobe.

Configuration writes land in a holding register. The working copy used by the sequencer and the shifter is refreshed only while no transfer is in flight, so a change never disturbs the transfer in progress. Three sticky status flags report events: finished, halted and mode fault. Software clears each flag by writing 1 to it. The flags drive one interrupt output through two enables. A halt request lets the current entry complete and then stops the walk. A mode fault aborts the walk at once.

Top module: `qseq_top`

## Requirements
- R1: After reset every configuration bit is 0, so `cfg_rdata` reads 0. After reset `busy`, `flags`, `irq` and `sdo` are also 0.
- R2: A `go` pulse while idle starts the walk at the start pointer (`cfg` bits [3:0]). Exactly one transfer is made per entry, in ascending address order. In the cycle where `rx_valid` is high, `cur_ptr` gives the entry that just completed.
- R3: With wrap enable (`cfg` bit 8) at 0, the walk stops when the end-pointer entry (`cfg` bits [7:4]) completes. `busy` then falls and the finished flag (`flags[0]`) sets.
- R4: With wrap enable at 1 and wrap-to (`cfg` bit 9) at 0, the entry after the end entry is address 0. The finished flag sets again on every pass through the end address.
- R5: With wrap enable at 1 and wrap-to at 1, the entry after the end entry is the start pointer.
- R6: A write with `cfg_wr` goes to a holding register. `cfg_rdata` returns the configuration in effect, not the held value. A write made during a transfer is not visible on `cfg_rdata` until that transfer ends, and it governs the walk from the next transfer on.
- R7: Each flag stays set until software writes 1 to its bit of `clr_mask` with `clr_wr`. With the finished enable (`cfg` bit 10) at 1, a set finished flag drives `irq` high.
- R8: With the finished enable at 0, the finished flag still sets, but it does not drive `irq`.
- R9: A `halt_req` pulse during a walk lets the current entry complete. The walk then stops and sets the halt flag (`flags[1]`). With the error enable (`cfg` bit 11) at 1, the halt flag drives `irq`.
- R10: A `mode_fault` pulse ends the walk at once and no further `rx_valid` is produced. It sets the mode-fault flag (`flags[2]`), which drives `irq` when the error enable is 1.
- R11: Each transfer shifts the word out MSB first on `sdo`, one bit per clock, and returns the received word on `rx_data`. With loop mode (`cfg` bit 12) at 1 the shifter receives its own `sdo`, so `rx_data` equals the word sent. With loop mode at 0 it samples `sdi`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_wr | input | 1 | Write strobe for the configuration holding register |
| cfg_wdata | input | 13 | Configuration write data: start [3:0], end [7:4], wrap enable 8, wrap-to 9, finished enable 10, error enable 11, loop mode 12 |
| cfg_rdata | output | 13 | Configuration currently in effect |
| go | input | 1 | Start pulse, accepted while idle |
| halt_req | input | 1 | Request to stop after the current entry |
| mode_fault | input | 1 | Fault pulse that aborts the walk |
| clr_wr | input | 1 | Flag clear strobe |
| clr_mask | input | 3 | Write-1-to-clear mask: bit 0 finished, bit 1 halt, bit 2 mode fault |
| tx_data | input | 8 | Word to send for the entry at `cur_ptr` |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out |
| rx_valid | output | 1 | One-cycle strobe when an entry completes |
| rx_data | output | 8 | Word received by the last transfer |
| busy | output | 1 | Walk in progress |
| cur_ptr | output | 4 | Queue pointer of the entry being executed |
| flags | output | 3 | Sticky flags: finished, halt, mode fault |
| irq | output | 1 | Interrupt output |

## Verification
The hardest case to reach is a configuration write that lands while a transfer is in flight. The bench starts a long walk and waits a few cycles so the first entry is shifting. It then moves the end pointer down. While that entry is still busy, the bench checks that `cfg_rdata` still shows the old end pointer. It then checks that the walk stops at the new end pointer. The second hard case is the finished flag being raised again on a later wrap pass. The bench clears the flag between passes while the walk continues, and checks that the flag sets again at the next pass through the end address.

// File: rtl/qseq_pkg.sv
package qseq_pkg;

  typedef struct packed {
    logic loop_en;
    logic err_ie;
    logic fin_ie;
    logic wrap_to;
    logic wrap_en;
  } qs_ctl_t;

  localparam int QS_CTL_W = $bits(qs_ctl_t);

  typedef enum logic [1:0] {
    QS_IDLE  = 2'd0,
    QS_ISSUE = 2'd1,
    QS_WAIT  = 2'd2
  } qs_state_e;

  localparam int QS_NFLAGS = 3;

endpackage

// File: rtl/qseq_cfg.sv
module qseq_cfg #(
  parameter int CFG_W = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [CFG_W-1:0] wdata,
  input  logic             xfer_busy,
  output logic [CFG_W-1:0] act
);

  logic [CFG_W-1:0] hold_q, hold_d;
  logic [CFG_W-1:0] act_q, act_d;

  always_comb begin
    hold_d = hold_q;
    if (wr) hold_d = wdata;
    act_d = act_q;
    if (!xfer_busy) act_d = hold_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
      act_q  <= '0;
    end else begin
      hold_q <= hold_d;
      act_q  <= act_d;
    end
  end

  assign act = act_q;

  AST_ACT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_busy && $past(xfer_busy)) |-> $stable(act_q)); // R6

endmodule

// File: rtl/qseq_shift.sv
module qseq_shift #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          abort,
  input  logic          loop_en,
  input  logic [DW-1:0] tx_data,
  input  logic          sdi,
  output logic          sdo,
  output logic          busy,
  output logic          done,
  output logic [DW-1:0] rx_data
);

  localparam int CNT_W = (DW > 1) ? $clog2(DW) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DW - 1);

  logic [DW-1:0]    sh_q, sh_d;
  logic [DW-1:0]    rx_q, rx_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             busy_q, busy_d;
  logic             done_q, done_d;
  logic             in_bit;
  logic [DW-1:0]    sh_next;

  assign in_bit  = loop_en ? sh_q[DW-1] : sdi;
  assign sh_next = {sh_q[DW-2:0], in_bit};

  always_comb begin
    sh_d   = sh_q;
    rx_d   = rx_q;
    cnt_d  = cnt_q;
    busy_d = busy_q;
    done_d = 1'b0;
    if (abort) begin
      busy_d = 1'b0;
      cnt_d  = '0;
    end else if (busy_q) begin
      sh_d  = sh_next;
      cnt_d = cnt_q + 1'b1;
      if (cnt_q == LAST) begin
        busy_d = 1'b0;
        done_d = 1'b1;
        rx_d   = sh_next;
        cnt_d  = '0;
      end
    end else if (start) begin
      sh_d   = tx_data;
      cnt_d  = '0;
      busy_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      rx_q   <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      sh_q   <= sh_d;
      rx_q   <= rx_d;
      cnt_q  <= cnt_d;
      busy_q <= busy_d;
      done_q <= done_d;
    end
  end

  assign sdo     = sh_q[DW-1];
  assign busy    = busy_q;
  assign done    = done_q;
  assign rx_data = rx_q;

  AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy))); // R11

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R11

endmodule

// File: rtl/qseq_ctrl.sv
module qseq_ctrl
  import qseq_pkg::*;
#(
  parameter int PTR_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PTR_W-1:0] start_ptr,
  input  logic [PTR_W-1:0] end_ptr,
  input  logic             wrap_en,
  input  logic             wrap_to,
  input  logic             go,
  input  logic             halt_req,
  input  logic             mode_fault,
  input  logic             xfer_done,
  output logic             xfer_req,
  output logic [PTR_W-1:0] cur_ptr,
  output logic             busy,
  output logic             fin_evt,
  output logic             halt_evt,
  output logic             modf_evt
);

  qs_state_e        state_q, state_d;
  logic [PTR_W-1:0] ptr_q, ptr_d;
  logic             hpend_q, hpend_d;
  logic             stop_now;

  assign stop_now = hpend_q || halt_req;

  always_comb begin
    state_d  = state_q;
    ptr_d    = ptr_q;
    hpend_d  = hpend_q;
    fin_evt  = 1'b0;
    halt_evt = 1'b0;
    modf_evt = mode_fault;
    if (state_q != QS_IDLE && halt_req) hpend_d = 1'b1;
    if (mode_fault) begin
      state_d = QS_IDLE;
      hpend_d = 1'b0;
    end else begin
      case (state_q)
        QS_IDLE: begin
          hpend_d = 1'b0;
          if (go) begin
            ptr_d   = start_ptr;
            state_d = QS_ISSUE;
          end
        end
        QS_ISSUE: state_d = QS_WAIT;
        QS_WAIT: begin
          if (xfer_done) begin
            if (stop_now) begin
              halt_evt = 1'b1;
              hpend_d  = 1'b0;
              state_d  = QS_IDLE;
            end else if (ptr_q == end_ptr) begin
              fin_evt = 1'b1;
              if (wrap_en) begin
                ptr_d   = wrap_to ? start_ptr : '0;
                state_d = QS_ISSUE;
              end else begin
                state_d = QS_IDLE;
              end
            end else begin
              ptr_d   = ptr_q + 1'b1;
              state_d = QS_ISSUE;
            end
          end
        end
        default: state_d = QS_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= QS_IDLE;
      ptr_q   <= '0;
      hpend_q <= 1'b0;
    end else begin
      state_q <= state_d;
      ptr_q   <= ptr_d;
      hpend_q <= hpend_d;
    end
  end

  assign xfer_req = (state_q == QS_ISSUE);
  assign cur_ptr  = ptr_q;
  assign busy     = (state_q != QS_IDLE);

  AST_ONE_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_req |=> !xfer_req); // R2

  AST_STOP_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    (fin_evt && !wrap_en) |=> !busy); // R3

  AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (fin_evt && wrap_en && !wrap_to) |=> (cur_ptr == '0 && busy)); // R4

  AST_WRAP_START: assert property (@(posedge clk) disable iff (!rst_n)
    (fin_evt && wrap_en && wrap_to) |=> (cur_ptr == $past(start_ptr))); // R5

  AST_HALT_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    halt_evt |=> !busy); // R9

  AST_FAULT_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    mode_fault |=> !busy); // R10

endmodule

// File: rtl/qseq_flags.sv
module qseq_flags
  import qseq_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 fin_evt,
  input  logic                 halt_evt,
  input  logic                 modf_evt,
  input  logic                 clr_wr,
  input  logic [QS_NFLAGS-1:0] clr_mask,
  input  logic                 fin_ie,
  input  logic                 err_ie,
  output logic [QS_NFLAGS-1:0] flags,
  output logic                 irq
);

  logic [QS_NFLAGS-1:0] set_v;
  logic [QS_NFLAGS-1:0] flg_q, flg_d;

  assign set_v = {modf_evt, halt_evt, fin_evt};

  for (genvar i = 0; i < QS_NFLAGS; i++) begin : g_flag
    always_comb begin
      flg_d[i] = flg_q[i];
      if (clr_wr && clr_mask[i]) flg_d[i] = 1'b0;
      if (set_v[i])              flg_d[i] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flg_q[i] <= 1'b0;
      else        flg_q[i] <= flg_d[i];
    end

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (flg_q[i] && !(clr_wr && clr_mask[i])) |=> flg_q[i]); // R7
  end

  assign flags = flg_q;
  assign irq   = (flg_q[0] && fin_ie) || ((flg_q[1] || flg_q[2]) && err_ie);

  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (!fin_ie && !err_ie) |-> !irq); // R8

endmodule

// File: rtl/qseq_top.sv
module qseq_top
  import qseq_pkg::*;
#(
  parameter int PTR_W = 4,
  parameter int DW    = 8,
  localparam int CFG_W = 2 * PTR_W + QS_CTL_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_wr,
  input  logic [CFG_W-1:0]     cfg_wdata,
  output logic [CFG_W-1:0]     cfg_rdata,
  input  logic                 go,
  input  logic                 halt_req,
  input  logic                 mode_fault,
  input  logic                 clr_wr,
  input  logic [QS_NFLAGS-1:0] clr_mask,
  input  logic [DW-1:0]        tx_data,
  input  logic                 sdi,
  output logic                 sdo,
  output logic                 rx_valid,
  output logic [DW-1:0]        rx_data,
  output logic                 busy,
  output logic [PTR_W-1:0]     cur_ptr,
  output logic [QS_NFLAGS-1:0] flags,
  output logic                 irq
);

  logic [1:0]       rst_sync_q;
  logic             rst_s_n;
  logic [CFG_W-1:0] act;
  qs_ctl_t          ctl;
  logic [PTR_W-1:0] start_ptr, end_ptr;
  logic             xfer_req, xfer_busy, xfer_done;
  logic             fin_evt, halt_evt, modf_evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_s_n = rst_sync_q[1];

  assign start_ptr = act[PTR_W-1:0];
  assign end_ptr   = act[2*PTR_W-1:PTR_W];
  assign ctl       = qs_ctl_t'(act[CFG_W-1:2*PTR_W]);

  qseq_cfg #(.CFG_W(CFG_W)) u_cfg (
    .clk(clk), .rst_n(rst_s_n), .wr(cfg_wr), .wdata(cfg_wdata),
    .xfer_busy(xfer_busy), .act(act)
  );

  qseq_ctrl #(.PTR_W(PTR_W)) u_ctrl (
    .clk(clk), .rst_n(rst_s_n), .start_ptr(start_ptr), .end_ptr(end_ptr),
    .wrap_en(ctl.wrap_en), .wrap_to(ctl.wrap_to), .go(go),
    .halt_req(halt_req), .mode_fault(mode_fault), .xfer_done(xfer_done),
    .xfer_req(xfer_req), .cur_ptr(cur_ptr), .busy(busy),
    .fin_evt(fin_evt), .halt_evt(halt_evt), .modf_evt(modf_evt)
  );

  qseq_shift #(.DW(DW)) u_shift (
    .clk(clk), .rst_n(rst_s_n), .start(xfer_req), .abort(mode_fault),
    .loop_en(ctl.loop_en), .tx_data(tx_data), .sdi(sdi), .sdo(sdo),
    .busy(xfer_busy), .done(xfer_done), .rx_data(rx_data)
  );

  qseq_flags u_flags (
    .clk(clk), .rst_n(rst_s_n), .fin_evt(fin_evt), .halt_evt(halt_evt),
    .modf_evt(modf_evt), .clr_wr(clr_wr), .clr_mask(clr_mask),
    .fin_ie(ctl.fin_ie), .err_ie(ctl.err_ie), .flags(flags), .irq(irq)
  );

  assign cfg_rdata = act;
  assign rx_valid  = xfer_done;

  AST_VALID_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_s_n)
    rx_valid |-> busy); // R2

endmodule

// File: tb/sim_qseq_top.sv
module sim_qseq_top;

  logic        clk;
  logic        rst_n;
  logic        cfg_wr;
  logic [12:0] cfg_wdata;
  logic [12:0] cfg_rdata;
  logic        go, halt_req, mode_fault, clr_wr;
  logic [2:0]  clr_mask;
  logic [7:0]  tx_data;
  logic        sdi, sdo, rx_valid, busy, irq;
  logic [7:0]  rx_data;
  logic [3:0]  cur_ptr;
  logic [2:0]  flags;

  int errors = 0;
  int checks = 0;
  logic [3:0] lp [0:63];
  logic [7:0] ld [0:63];
  int nlog = 0;
  bit done_flag = 0;

  qseq_top u0 (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .go(go), .halt_req(halt_req),
    .mode_fault(mode_fault), .clr_wr(clr_wr), .clr_mask(clr_mask),
    .tx_data(tx_data), .sdi(sdi), .sdo(sdo), .rx_valid(rx_valid),
    .rx_data(rx_data), .busy(busy), .cur_ptr(cur_ptr), .flags(flags),
    .irq(irq)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  assign tx_data = {~cur_ptr, cur_ptr};

  always @(negedge clk) begin
    if (rx_valid && nlog < 64) begin
      lp[nlog] = cur_ptr;
      ld[nlog] = rx_data;
      nlog = nlog + 1;
    end
  end

  function automatic logic [12:0] mk(input logic [3:0] s, input logic [3:0] e,
                                     input logic wen, input logic wto,
                                     input logic fie, input logic eie,
                                     input logic lpm);
    return {lpm, eie, fie, wto, wen, e, s};
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    #1;
  endtask

  task automatic write_cfg(input logic [12:0] v);
    @(posedge clk); #1;
    cfg_wr = 1'b1; cfg_wdata = v;
    @(posedge clk); #1;
    cfg_wr = 1'b0;
    tick(2);
  endtask

  task automatic pulse_go();
    @(posedge clk); #1; go = 1'b1;
    @(posedge clk); #1; go = 1'b0;
  endtask

  task automatic pulse_halt();
    @(posedge clk); #1; halt_req = 1'b1;
    @(posedge clk); #1; halt_req = 1'b0;
  endtask

  task automatic clear_flags(input logic [2:0] m);
    @(posedge clk); #1; clr_wr = 1'b1; clr_mask = m;
    @(posedge clk); #1; clr_wr = 1'b0; clr_mask = 3'b000;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 2000 && busy; i++) @(posedge clk);
    tick(2);
  endtask

  task automatic wait_events(input int n);
    for (int i = 0; i < 2000 && nlog < n; i++) @(negedge clk);
  endtask

  task automatic prep();
    wait_idle();
    clear_flags(3'b111);
    tick(1);
    nlog = 0;
  endtask

  task automatic t_reset();
    check(cfg_rdata == 13'd0, "R1 cfg_rdata", int'(cfg_rdata), 0);
    check(!busy, "R1 busy", int'(busy), 0);
    check(flags == 3'b000, "R1 flags", int'(flags), 0);
    check(!irq && !sdo, "R1 irq/sdo", int'({irq, sdo}), 0);
  endtask

  task automatic t_single();
    prep();
    write_cfg(mk(4'd2, 4'd5, 0, 0, 1, 0, 1));
    check(cfg_rdata == mk(4'd2, 4'd5, 0, 0, 1, 0, 1), "R6 readback idle",
          int'(cfg_rdata), int'(mk(4'd2, 4'd5, 0, 0, 1, 0, 1)));
    pulse_go();
    wait_idle();
    check(nlog == 4, "R2 entry count", nlog, 4);
    for (int i = 0; i < 4; i++) begin
      check(lp[i] == 4'(2 + i), "R2 order", int'(lp[i]), 2 + i);
      check(ld[i] == {~lp[i], lp[i]}, "R11 loopback data", int'(ld[i]),
            int'({~lp[i], lp[i]}));
    end
    check(flags[0] && !busy, "R3 stop and finished", int'({flags[0], busy}), 2);
    check(irq, "R7 finished irq", int'(irq), 1);
    tick(5);
    check(flags[0], "R7 sticky", int'(flags[0]), 1);
    clear_flags(3'b001);
    tick(1);
    check(!flags[0] && !irq, "R7 clear", int'({flags[0], irq}), 0);
  endtask

  task automatic t_nofin_irq();
    prep();
    sdi = 1'b1;
    write_cfg(mk(4'd7, 4'd7, 0, 0, 0, 0, 0));
    pulse_go();
    wait_idle();
    check(nlog == 1, "R3 single entry", nlog, 1);
    check(ld[0] == 8'hFF, "R11 sdi sampled", int'(ld[0]), 255);
    check(flags[0], "R8 flag sets", int'(flags[0]), 1);
    check(!irq, "R8 irq masked", int'(irq), 0);
    sdi = 1'b0;
  endtask

  task automatic t_wrap0();
    int exp_seq [7] = '{2, 3, 0, 1, 2, 3, 0};
    prep();
    write_cfg(mk(4'd2, 4'd3, 1, 0, 0, 1, 1));
    pulse_go();
    wait_events(2);
    tick(2);
    check(flags[0] && busy, "R4 finished on pass, still running",
          int'({flags[0], busy}), 3);
    check(!irq, "R8 fin masked while wrapping", int'(irq), 0);
    clear_flags(3'b001);
    check(!flags[0], "R7 clear mid-run", int'(flags[0]), 0);
    wait_events(6);
    tick(2);
    check(flags[0], "R4 finished again next pass", int'(flags[0]), 1);
    wait_events(7);
    for (int i = 0; i < 7; i++)
      check(int'(lp[i]) == exp_seq[i], "R4 wrap to zero order", int'(lp[i]), exp_seq[i]);
    pulse_halt();
    wait_idle();
    check(!busy && flags[1], "R9 halted", int'({busy, flags[1]}), 1);
    check(irq, "R9 halt irq", int'(irq), 1);
    check(nlog <= 9, "R9 stops after current entry", nlog, 9);
  endtask

  task automatic t_wrap1();
    int exp_seq [7] = '{4, 5, 6, 4, 5, 6, 4};
    prep();
    write_cfg(mk(4'd4, 4'd6, 1, 1, 0, 0, 1));
    pulse_go();
    wait_events(7);
    for (int i = 0; i < 7; i++)
      check(int'(lp[i]) == exp_seq[i], "R5 wrap to start order", int'(lp[i]), exp_seq[i]);
    pulse_halt();
    wait_idle();
    check(!busy && flags[1] && !irq, "R9 halt without irq enable",
          int'({busy, flags[1], irq}), 2);
  endtask

  task automatic t_buffer();
    prep();
    write_cfg(mk(4'd0, 4'd7, 0, 0, 0, 0, 1));
    pulse_go();
    tick(2);
    @(posedge clk); #1;
    cfg_wr = 1'b1; cfg_wdata = mk(4'd0, 4'd1, 0, 0, 0, 0, 1);
    @(posedge clk); #1;
    cfg_wr = 1'b0;
    tick(1);
    check(cfg_rdata[7:4] == 4'd7, "R6 rdata holds active during transfer",
          int'(cfg_rdata[7:4]), 7);
    wait_idle();
    check(nlog == 2, "R6 new end from next transfer", nlog, 2);
    check(lp[0] == 4'd0 && lp[1] == 4'd1, "R6 entries", int'({lp[0], lp[1]}), 1);
    check(cfg_rdata[7:4] == 4'd1, "R6 rdata updated", int'(cfg_rdata[7:4]), 1);
  endtask

  task automatic t_modf();
    int n;
    prep();
    write_cfg(mk(4'd0, 4'd15, 0, 0, 0, 1, 1));
    pulse_go();
    wait_events(1);
    tick(3);
    @(posedge clk); #1; mode_fault = 1'b1;
    @(posedge clk); #1; mode_fault = 1'b0;
    n = nlog;
    tick(30);
    check(!busy, "R10 aborted", int'(busy), 0);
    check(nlog == n, "R10 no further entries", nlog, n);
    check(flags[2] && irq, "R10 fault flag and irq", int'({flags[2], irq}), 3);
    clear_flags(3'b100);
    tick(1);
    check(flags == 3'b000 && !irq, "R7 fault clear", int'(flags), 0);
  endtask

  initial begin
    #(8 * 150000);
    if (!done_flag) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cfg_wr = 1'b0; cfg_wdata = '0; go = 1'b0;
    halt_req = 1'b0; mode_fault = 1'b0; clr_wr = 1'b0; clr_mask = '0;
    sdi = 1'b0;
    tick(3);
    rst_n = 1'b1;
    tick(4);
    t_reset();
    t_single();
    t_nofin_irq();
    t_wrap0();
    t_wrap1();
    t_buffer();
    t_modf();
    done_flag = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule